// File: doc/BRIEF.md
# Stack-Top Register Cache with Memory Spill

This block keeps the newest entries of one thread's traversal stack in a small set of registers. Deeper entries live in a backing memory that the block reaches through a request/response port. The traversal logic sends push and pop requests. When a push arrives and the register window is already full, the oldest cached entry is written out to memory first. When a pop arrives and the window is empty but entries remain in memory, the newest spilled entry is read back and returned directly.

When the thread is suspended, a flush command writes every cached entry to memory, oldest first, so that the whole stack sits in memory as one contiguous region. When the thread resumes, a restore command reads the newest spilled entries back until the window is full or memory holds no more. A pop on a stack that is empty everywhere returns an empty indication, which tells the traversal logic that it has finished.

Memory addresses count entries from the bottom of the stack, starting at 0. Spilled entry k sits at address k. The window is a circular buffer with a head pointer and a valid count. A separate counter records how many entries have been spilled. With the default parameters each entry is 32 bits wide and the window holds 4 entries. A flush therefore moves at most 128 bits in consecutive-address writes, which a memory front end can merge into one minimum-size transfer.

Top module: `stack_top_cache`

## Requirements
- R1: After reset, `ready` is 1, `memReqValid` is 0, `popDone` is 0, and the stack is empty both in the window and in memory.
- R2: While the window holds fewer than WIN entries (default 4), a push is accepted in its own cycle. `ready` stays 1 and no memory request is made.
- R3: A push that finds the window full first writes the oldest cached entry. The write goes to the address equal to the spilled-entry count. `ready` stays low until memory accepts the write. A stalled request holds its valid, write flag, address and data unchanged.
- R4: A pop served from the window returns the newest entry on `popData`, with `popDone` high for one cycle, one cycle after the request is accepted. Entries come back in last-in first-out order across the window and memory.
- R5: A pop that finds the window empty and the spilled count N > 0 issues a read of address N-1. It then returns the response data with `popDone` one cycle after `memRspValid`.
- R6: A pop on a stack that is empty in both window and memory raises `popDone` together with `popEmpty` (1 = empty), and makes no memory request.
- R7: A flush writes every cached entry, oldest first, to consecutive increasing addresses. After the flush the window is empty. A flush of an empty window makes no memory request.
- R8: A restore reads entries newest first, at decreasing addresses, until the window holds WIN entries or the spilled count reaches 0. Later pops of those entries make no memory request.
- R9: If several requests are raised in the same accepted cycle, only one is taken: flush first, then restore, then push, then pop. The others are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| pushReq | input | 1 | Push request, taken when `ready` is 1 |
| pushData | input | DATA_W | Entry to push |
| popReq | input | 1 | Pop request, taken when `ready` is 1 |
| flushReq | input | 1 | Write all cached entries to memory (on suspend) |
| restoreReq | input | 1 | Reload the window from memory (on resume) |
| ready | output | 1 | Block idle, can take a request this cycle |
| popDone | output | 1 | One-cycle pulse, pop result valid |
| popEmpty | output | 1 | With `popDone`: stack was empty |
| popData | output | DATA_W | Popped entry |
| memReqValid | output | 1 | Memory request valid |
| memReqReady | input | 1 | Memory accepts the request this cycle |
| memReqWrite | output | 1 | 1 = write, 0 = read |
| memReqAddr | output | DEPTH_W | Entry address, counted from stack bottom |
| memReqData | output | DATA_W | Write data |
| memRspValid | input | 1 | Read response valid |
| memRspData | input | DATA_W | Read response data |

## Verification
The bound checker watches these points on every cycle:
- A stalled memory request stays unchanged while it waits.
- Consecutive accepted writes go to consecutive addresses.
- `popEmpty` never appears without `popDone`.
- Every `popDone` traces back to either a pop request or a memory response.
- `ready` and a memory request are never active together.

Some behaviour only the bench scenarios can show:
- The value order across window and memory.
- The exact count of memory transactions for a given push, pop, flush and restore sequence.
- Request priority.
- The empty indication.

The bench tracks these against a behavioural stack held in a queue.

// File: rtl/stack_top_cache_pkg.sv
package stack_top_cache_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SPILL,
    ST_FILL_REQ,
    ST_FILL_WAIT,
    ST_FLUSH,
    ST_RST_REQ,
    ST_RST_WAIT
  } ctrlState_t;

  // strobes from control to datapath; at most one action strobe per cycle
  typedef struct packed {
    logic doPush;     // store into window, no spill
    logic doLatch;    // capture push data while a spill is pending
    logic doSpill;    // oldest written out; pending entry becomes new top
    logic doPop;      // return window top
    logic doFill;     // return memory response
    logic doFlush;    // oldest written out, window shrinks
    logic doRestore;  // memory response stored as new oldest
    logic doEmpty;    // signal empty stack
    logic reqWrite;   // address select for the memory port
  } dpStrobe_t;

endpackage

// File: rtl/stack_top_cache_dp.sv
module stack_top_cache_dp
  import stack_top_cache_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int WIN     = 4,
  parameter int DEPTH_W = 10,
  localparam int PTR_W  = $clog2(WIN),
  localparam int CNT_W  = $clog2(WIN + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  logic [DATA_W-1:0]  pushData,
  input  logic [DATA_W-1:0]  memRspData,
  output logic [CNT_W-1:0]   cachedCnt,
  output logic [DEPTH_W-1:0] memDepth,
  output logic [DEPTH_W-1:0] memReqAddr,
  output logic [DATA_W-1:0]  memReqData,
  output logic               popDone,
  output logic               popEmpty,
  output logic [DATA_W-1:0]  popData
);

  logic [DATA_W-1:0] slots [WIN];
  logic [PTR_W-1:0]  head;
  logic [DATA_W-1:0] pendReg;
  logic [PTR_W-1:0]  nextTop;
  logic [PTR_W-1:0]  oldestIdx;
  logic [PTR_W-1:0]  restoreIdx;
  logic [DATA_W-1:0] slotWrData;

  assign nextTop    = head + PTR_W'(1);
  assign oldestIdx  = head + PTR_W'(1) - PTR_W'(cachedCnt);
  assign restoreIdx = head - PTR_W'(cachedCnt);
  assign slotWrData = strobe.doRestore ? memRspData :
                      strobe.doSpill   ? pendReg    : pushData;

  assign memReqAddr = strobe.reqWrite ? memDepth : memDepth - DEPTH_W'(1);
  assign memReqData = slots[oldestIdx];

  for (genvar i = 0; i < WIN; i++) begin : gSlot
    logic slotWe;
    assign slotWe = ((strobe.doPush || strobe.doSpill) && nextTop == PTR_W'(i)) ||
                    (strobe.doRestore && restoreIdx == PTR_W'(i));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       slots[i] <= '0;
      else if (slotWe) slots[i] <= slotWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      head      <= '0;
      cachedCnt <= '0;
      memDepth  <= '0;
      pendReg   <= '0;
      popDone   <= 1'b0;
      popEmpty  <= 1'b0;
      popData   <= '0;
    end else begin
      popDone  <= 1'b0;
      popEmpty <= 1'b0;
      if (strobe.doLatch) pendReg <= pushData;
      if (strobe.doPush) begin
        head      <= nextTop;
        cachedCnt <= cachedCnt + CNT_W'(1);
      end
      if (strobe.doSpill) begin
        head     <= nextTop;
        memDepth <= memDepth + DEPTH_W'(1);
      end
      if (strobe.doPop) begin
        head      <= head - PTR_W'(1);
        cachedCnt <= cachedCnt - CNT_W'(1);
        popDone   <= 1'b1;
        popData   <= slots[head];
      end
      if (strobe.doFill) begin
        memDepth <= memDepth - DEPTH_W'(1);
        popDone  <= 1'b1;
        popData  <= memRspData;
      end
      if (strobe.doFlush) begin
        cachedCnt <= cachedCnt - CNT_W'(1);
        memDepth  <= memDepth + DEPTH_W'(1);
      end
      if (strobe.doRestore) begin
        cachedCnt <= cachedCnt + CNT_W'(1);
        memDepth  <= memDepth - DEPTH_W'(1);
      end
      if (strobe.doEmpty) begin
        popDone  <= 1'b1;
        popEmpty <= 1'b1;
        popData  <= '0;
      end
    end
  end

endmodule

// File: rtl/stack_top_cache_ctrl.sv
module stack_top_cache_ctrl
  import stack_top_cache_pkg::*;
#(
  parameter int WIN     = 4,
  parameter int DEPTH_W = 10,
  localparam int CNT_W  = $clog2(WIN + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pushReq,
  input  logic               popReq,
  input  logic               flushReq,
  input  logic               restoreReq,
  input  logic [CNT_W-1:0]   cachedCnt,
  input  logic [DEPTH_W-1:0] memDepth,
  input  logic               memReqReady,
  input  logic               memRspValid,
  output logic               ready,
  output logic               memReqValid,
  output logic               memReqWrite,
  output dpStrobe_t          strobe
);

  ctrlState_t state, stateNext;
  logic winFull, winEmpty, memEmpty;

  assign winFull  = (cachedCnt == CNT_W'(WIN));
  assign winEmpty = (cachedCnt == '0);
  assign memEmpty = (memDepth == '0);

  always_comb begin
    stateNext   = state;
    strobe      = '0;
    memReqValid = 1'b0;
    memReqWrite = 1'b0;
    ready       = (state == ST_IDLE);
    unique case (state)
      ST_IDLE: begin
        if (flushReq) begin
          if (!winEmpty) stateNext = ST_FLUSH;
        end else if (restoreReq) begin
          if (!winFull && !memEmpty) stateNext = ST_RST_REQ;
        end else if (pushReq) begin
          if (!winFull) strobe.doPush = 1'b1;
          else begin
            strobe.doLatch = 1'b1;
            stateNext      = ST_SPILL;
          end
        end else if (popReq) begin
          if (!winEmpty)      strobe.doPop = 1'b1;
          else if (!memEmpty) stateNext = ST_FILL_REQ;
          else                strobe.doEmpty = 1'b1;
        end
      end
      ST_SPILL: begin
        memReqValid = 1'b1;
        memReqWrite = 1'b1;
        if (memReqReady) begin
          strobe.doSpill = 1'b1;
          stateNext      = ST_IDLE;
        end
      end
      ST_FILL_REQ: begin
        memReqValid = 1'b1;
        if (memReqReady) stateNext = ST_FILL_WAIT;
      end
      ST_FILL_WAIT: begin
        if (memRspValid) begin
          strobe.doFill = 1'b1;
          stateNext     = ST_IDLE;
        end
      end
      ST_FLUSH: begin
        memReqValid = 1'b1;
        memReqWrite = 1'b1;
        if (memReqReady) begin
          strobe.doFlush = 1'b1;
          if (cachedCnt == CNT_W'(1)) stateNext = ST_IDLE;
        end
      end
      ST_RST_REQ: begin
        memReqValid = 1'b1;
        if (memReqReady) stateNext = ST_RST_WAIT;
      end
      ST_RST_WAIT: begin
        if (memRspValid) begin
          strobe.doRestore = 1'b1;
          if (cachedCnt == CNT_W'(WIN - 1) || memDepth == DEPTH_W'(1))
            stateNext = ST_IDLE;
          else
            stateNext = ST_RST_REQ;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
    strobe.reqWrite = memReqWrite;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/stack_top_cache.sv
module stack_top_cache
  import stack_top_cache_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int WIN     = 4,
  parameter int DEPTH_W = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pushReq,
  input  logic [DATA_W-1:0]  pushData,
  input  logic               popReq,
  input  logic               flushReq,
  input  logic               restoreReq,
  output logic               ready,
  output logic               popDone,
  output logic               popEmpty,
  output logic [DATA_W-1:0]  popData,
  output logic               memReqValid,
  input  logic               memReqReady,
  output logic               memReqWrite,
  output logic [DEPTH_W-1:0] memReqAddr,
  output logic [DATA_W-1:0]  memReqData,
  input  logic               memRspValid,
  input  logic [DATA_W-1:0]  memRspData
);

  localparam int CNT_W = $clog2(WIN + 1);

  dpStrobe_t          strobe;
  logic [CNT_W-1:0]   cachedCnt;
  logic [DEPTH_W-1:0] memDepth;

  stack_top_cache_ctrl #(.WIN(WIN), .DEPTH_W(DEPTH_W)) ctrlInst (
    .clk        (clk),
    .rstN       (rstN),
    .pushReq    (pushReq),
    .popReq     (popReq),
    .flushReq   (flushReq),
    .restoreReq (restoreReq),
    .cachedCnt  (cachedCnt),
    .memDepth   (memDepth),
    .memReqReady(memReqReady),
    .memRspValid(memRspValid),
    .ready      (ready),
    .memReqValid(memReqValid),
    .memReqWrite(memReqWrite),
    .strobe     (strobe)
  );

  stack_top_cache_dp #(.DATA_W(DATA_W), .WIN(WIN), .DEPTH_W(DEPTH_W)) dpInst (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .pushData  (pushData),
    .memRspData(memRspData),
    .cachedCnt (cachedCnt),
    .memDepth  (memDepth),
    .memReqAddr(memReqAddr),
    .memReqData(memReqData),
    .popDone   (popDone),
    .popEmpty  (popEmpty),
    .popData   (popData)
  );

endmodule

// File: rtl/stack_top_cache_chk.sv
module stack_top_cache_chk #(
  parameter int DATA_W  = 32,
  parameter int DEPTH_W = 10
) (
  input logic               clk,
  input logic               rstN,
  input logic               popReq,
  input logic               ready,
  input logic               popDone,
  input logic               popEmpty,
  input logic               memReqValid,
  input logic               memReqReady,
  input logic               memReqWrite,
  input logic [DEPTH_W-1:0] memReqAddr,
  input logic [DATA_W-1:0]  memReqData,
  input logic               memRspValid
);

  // R3
  stalled_req_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqWrite) &&
                                       $stable(memReqAddr) && $stable(memReqData)));

  // R7
  flush_addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqWrite && $past(memReqValid && memReqReady && memReqWrite))
      |-> (memReqAddr == $past(memReqAddr) + DEPTH_W'(1)));

  // R6
  empty_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    popEmpty |-> (popDone && !memReqValid));

  // R4
  done_has_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    popDone |-> ($past(popReq && ready) || $past(memRspValid)));

  // R1
  idle_no_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ready && memReqValid));

endmodule

bind stack_top_cache stack_top_cache_chk #(.DATA_W(DATA_W), .DEPTH_W(DEPTH_W)) chkInst (
  .clk        (clk),
  .rstN       (rstN),
  .popReq     (popReq),
  .ready      (ready),
  .popDone    (popDone),
  .popEmpty   (popEmpty),
  .memReqValid(memReqValid),
  .memReqReady(memReqReady),
  .memReqWrite(memReqWrite),
  .memReqAddr (memReqAddr),
  .memReqData (memReqData),
  .memRspValid(memRspValid)
);

// File: tb/stack_top_cache_test.sv
`timescale 1ns/1ps
module stack_top_cache_test;

  localparam int DATA_W  = 32;
  localparam int WIN     = 4;
  localparam int DEPTH_W = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pushReq = 1'b0, popReq = 1'b0, flushReq = 1'b0, restoreReq = 1'b0;
  logic [DATA_W-1:0] pushData = '0;
  logic ready, popDone, popEmpty, memReqValid, memReqWrite;
  logic [DATA_W-1:0] popData, memReqData;
  logic [DEPTH_W-1:0] memReqAddr;
  logic memReqReady = 1'b1, memRspValid = 1'b0;
  logic [DATA_W-1:0] memRspData = '0;

  stack_top_cache #(.DATA_W(DATA_W), .WIN(WIN), .DEPTH_W(DEPTH_W)) uut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  int wrCount = 0, rdCount = 0, rspTimer = 0, stallMode = 0;
  logic [DEPTH_W-1:0] rdAddr = '0;
  logic [DATA_W-1:0] memArr [1 << DEPTH_W];
  logic [DATA_W-1:0] stackQ [$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural memory, evaluated at negedge (requests are handshaken at the next posedge)
  always @(negedge clk) begin
    cycles++;
    memReqReady = (stallMode == 0) ? 1'b1 : ((cycles % 3) == 0);
    if (rspTimer == 1) begin
      memRspValid = 1'b1;
      memRspData  = memArr[rdAddr];
    end else begin
      memRspValid = 1'b0;
    end
    if (rspTimer > 0) rspTimer--;
    if (rstN && memReqValid && memReqReady) begin
      if (memReqWrite) begin
        wrCount++;
        // R3 R7: memory slot k must hold the k-th entry from the stack bottom
        check(int'(memReqAddr) < stackQ.size() && memReqData == stackQ[memReqAddr],
              "R3/R7", "spill write data", memReqData,
              (int'(memReqAddr) < stackQ.size()) ? stackQ[memReqAddr] : '1);
        memArr[memReqAddr] = memReqData;
      end else begin
        rdCount++;
        rdAddr   = memReqAddr;
        rspTimer = 2;
      end
    end
  end

  always @(posedge clk) begin
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired actual %0d expected %0d", cycles, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic waitReady();
    while (!ready) @(negedge clk);
  endtask

  task automatic doPush(input logic [DATA_W-1:0] d);
    waitReady();
    pushReq = 1'b1; pushData = d;
    stackQ.push_back(d);
    @(negedge clk);
    pushReq = 1'b0;
    waitReady();
  endtask

  task automatic doPop();
    int n;
    logic [DATA_W-1:0] exp;
    waitReady();
    popReq = 1'b1;
    @(negedge clk);
    popReq = 1'b0;
    n = 0;
    while (!popDone && n < 100) begin @(negedge clk); n++; end
    if (stackQ.size() == 0) begin
      check(popDone && popEmpty, "R6", "empty indication", {30'd0, popDone, popEmpty}, 32'h3);
    end else begin
      exp = stackQ.pop_back();
      check(popDone && !popEmpty && popData == exp, "R4", "pop value", popData, exp);
    end
    waitReady();
  endtask

  task automatic doFlush();
    waitReady();
    flushReq = 1'b1;
    @(negedge clk);
    flushReq = 1'b0;
    @(negedge clk);
    waitReady();
  endtask

  task automatic doRestore();
    waitReady();
    restoreReq = 1'b1;
    @(negedge clk);
    restoreReq = 1'b0;
    @(negedge clk);
    waitReady();
  endtask

  initial begin
    int w0, r0;
    logic [31:0] lcg;
    repeat (3) @(negedge clk);
    // R1
    check(ready && !memReqValid && !popDone, "R1", "reset outputs",
          {29'd0, ready, memReqValid, popDone}, 32'h4);
    rstN = 1'b1;
    @(negedge clk);

    // R2: four pushes fill the window without traffic, each taken in one cycle
    for (int i = 0; i < WIN; i++) begin
      waitReady();
      pushReq = 1'b1; pushData = 32'hA0 + i; stackQ.push_back(32'hA0 + i);
      @(negedge clk);
      pushReq = 1'b0;
      check(ready == 1'b1, "R2", "ready after push", {31'd0, ready}, 32'd1);
    end
    check(wrCount == 0, "R2", "no writes while window fills", wrCount, 0);

    // R3: fifth push spills the oldest to address 0
    doPush(32'hA4);
    check(wrCount == 1, "R3", "one spill write", wrCount, 1);
    check(memArr[0] == 32'hA0, "R3", "oldest at address 0", memArr[0], 32'hA0);
    stallMode = 1;
    doPush(32'hA5);
    doPush(32'hA6);
    stallMode = 0;
    check(wrCount == 3, "R3", "spills under stall", wrCount, 3);

    // R4: window pops without reads
    r0 = rdCount;
    for (int i = 0; i < WIN; i++) doPop();
    check(rdCount == r0, "R4", "window pops need no reads", rdCount, r0);

    // R5: further pops fill from memory
    for (int i = 0; i < 3; i++) doPop();
    check(rdCount == r0 + 3, "R5", "one read per fill pop", rdCount, r0 + 3);

    // R6: empty stack
    w0 = wrCount; r0 = rdCount;
    doPop();
    check(wrCount == w0 && rdCount == r0, "R6", "no traffic on empty pop",
          wrCount + rdCount, w0 + r0);

    // R7: flush
    for (int i = 1; i <= 6; i++) doPush(i);
    w0 = wrCount;
    doFlush();
    check(wrCount == w0 + WIN, "R7", "flush writes whole window", wrCount, w0 + WIN);
    check(memArr[5] == 32'd6 && memArr[2] == 32'd3, "R7", "flush order",
          memArr[5], 32'd6);
    w0 = wrCount; r0 = rdCount;
    doFlush();
    check(wrCount == w0 && rdCount == r0, "R7", "empty flush no traffic", wrCount, w0);

    // R8: restore
    r0 = rdCount;
    doRestore();
    check(rdCount == r0 + WIN, "R8", "restore reads a full window", rdCount, r0 + WIN);
    for (int i = 0; i < WIN; i++) doPop();
    check(rdCount == r0 + WIN, "R8", "restored pops need no reads", rdCount, r0 + WIN);
    doPop();
    r0 = rdCount;
    doRestore();
    check(rdCount == r0 + 1, "R8", "restore stops at memory bottom", rdCount, r0 + 1);
    doPop();
    check(rdCount == r0 + 1, "R8", "last restored pop local", rdCount, r0 + 1);
    doPop();

    // R9: push wins over a simultaneous pop
    doPush(32'h55);
    waitReady();
    pushReq = 1'b1; popReq = 1'b1; pushData = 32'h77; stackQ.push_back(32'h77);
    @(negedge clk);
    pushReq = 1'b0; popReq = 1'b0;
    check(popDone == 1'b0, "R9", "pop dropped when push taken", {31'd0, popDone}, 0);
    doPop();
    doPop();

    // mixed sequence with stalls
    lcg = 32'h1234_5678;
    for (int i = 0; i < 600; i++) begin
      lcg = lcg * 32'd1103515245 + 32'd12345;
      stallMode = (i >= 300) ? 1 : 0;
      case (lcg[18:16])
        3'd0, 3'd1, 3'd2, 3'd3: if (stackQ.size() < 200) doPush(lcg ^ 32'hC0DE0000);
        3'd4, 3'd5, 3'd6:       doPop();
        default: if (lcg[20]) doFlush(); else doRestore();
      endcase
    end
    while (stackQ.size() > 0) doPop();
    doPop();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule